// File: doc/BRIEF.md
# Coprocessor Dispatch Sequencer

This block sits next to a host processor's instruction decoder. It looks at each instruction word offered to it. A word whose top nibble is all ones is a coprocessor operation. For such a word, the block finds out which coprocessor is addressed and what kind of operation it is. It then delivers the complete word to that coprocessor's command register, which is reached through a memory-mapped coprocessor address space. Words with any other top nibble are handed straight back to the host pipeline and cause no bus traffic.

After the command write, the sequencer reads the coprocessor's response register and follows the coded reply. The coprocessor never masters the bus itself. When it needs an operand, it supplies the address in a follow-up response read. The host then reads memory at that address and writes the word into the coprocessor's operand register. When the coprocessor signals completion, the host is released with a one-cycle pulse and carries on in parallel. Three conditions end the dispatch in a one-cycle trap instead of a release: an identifier that is not fitted, a fault reply, or too many busy replies.

Top module: `cpDispatch`

## Requirements
- R1: A word offered while idle whose bits [15:12] are not 4'hF raises `passThru` in the same cycle and starts no bus transaction.
- R2: `decCpId` shows bits [11:9] and `decOpType` shows bits [8:6] of the offered word, combinationally.
- R3: An accepted coprocessor word is first written, zero-extended, to address (id << 13) | 0x0A with `busSpace`=1 and `busWrite`=1. While this runs, `instrReady` is low.
- R4: After the command write, and after every operand write, the response register at (id << 13) | 0x00 is read with `busSpace`=1 and `busWrite`=0. The reply code is `busRData[1:0]`.
- R5: Reply code 2'b00 ends the dispatch. `done` is high for exactly the one cycle after that handshake, and the block is idle in that cycle.
- R6: Reply code 2'b01 causes another response read. The 16th busy reply within one dispatch ends it with `trap` instead.
- R7: Reply code 2'b10 triggers the fetch sequence. First, one more response read returns a 32-bit address. Then memory is read at that address with `busSpace`=0. Then the returned word is written to (id << 13) | 0x10. Memory-space transactions are never writes.
- R8: While `busValid` is high and `busReady` is low, the address, write data, direction and space stay unchanged. `busValid` also stays high.
- R9: A coprocessor word whose id bit is clear in `PRESENT_MASK` (default: ids 0 and 1 fitted) is not accepted. It raises `trap` for one cycle and starts no bus transaction.
- R10: Reply code 2'b11 raises `trap` for the cycle after the handshake and returns to idle. No further command write follows.
- R11: During and after reset, the block is idle: `instrReady`=1, `busValid`=0, `trap`=0, `done`=0. A reset during a transaction drops `busValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrValid | input | 1 | An instruction word is offered |
| instrWord | input | INSTR_W | Offered instruction word |
| instrReady | output | 1 | Sequencer idle and able to take a word |
| passThru | output | 1 | Offered word is not a coprocessor word |
| decCpId | output | ID_W | Coprocessor identifier field of the offered word |
| decOpType | output | TYPE_W | Operation type field of the offered word |
| trap | output | 1 | One-cycle unimplemented-instruction trap |
| done | output | 1 | One-cycle release of the host |
| busValid | output | 1 | Bus transaction request |
| busWrite | output | 1 | 1 = write, 0 = read |
| busSpace | output | 1 | 1 = coprocessor space, 0 = memory |
| busAddr | output | ADDR_W | Transaction address |
| busWData | output | DATA_W | Write data |
| busReady | input | 1 | Transaction completes this cycle |
| busRData | input | DATA_W | Read data, sampled with busReady |

## Verification
The properties assume that `busReady` is only raised while `busValid` is high. They also assume that read data is meaningful only in the cycle a read completes. The bench's bus responder keeps to both rules. It waits for a request, holds `busReady` low for zero to two cycles, and then raises it together with the read data for exactly one cycle. Instruction words are offered only while `instrReady` is high and are withdrawn right after the accepting edge. So the busy-time behaviour of `passThru` is never exercised.

// File: rtl/cpDispatchPkg.sv
package cpDispatchPkg;

  // Sequencer state doubles as the bus operation in flight.
  typedef enum logic [2:0] {
    OP_NONE,
    OP_CMD,
    OP_RESP,
    OP_FADDR,
    OP_MEM,
    OP_OPND
  } busOpE;

  typedef enum logic [1:0] {
    RC_DONE  = 2'b00,
    RC_BUSY  = 2'b01,
    RC_FETCH = 2'b10,
    RC_FAULT = 2'b11
  } respE;

  // Strobes from control to datapath.
  typedef struct packed {
    busOpE op;
    logic  loadWord;
    logic  loadAddr;
    logic  loadData;
    logic  clrRetry;
    logic  bumpRetry;
  } ctlS;

endpackage

// File: rtl/cpDispatchCtrl.sv
module cpDispatchCtrl
  import cpDispatchPkg::*;
#(
  parameter int ID_W = 3,
  parameter logic [(1<<ID_W)-1:0] PRESENT_MASK = 'b11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instrValid,
  input  logic            isCp,
  input  logic [ID_W-1:0] inCpId,
  input  logic            busReady,
  input  logic [1:0]      respCode,
  input  logic            retryMax,
  output ctlS             ctl,
  output logic            instrReady,
  output logic            passThru,
  output logic            trap,
  output logic            done
);

  busOpE stateQ, stateD;
  logic  trapD, doneD;
  logic  idPresent;

  assign idPresent  = PRESENT_MASK[inCpId];
  assign instrReady = (stateQ == OP_NONE);
  assign passThru   = instrValid && instrReady && !isCp;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    ctl.op = stateQ;
    trapD  = 1'b0;
    doneD  = 1'b0;
    case (stateQ)
      OP_NONE: begin
        if (instrValid && isCp) begin
          if (idPresent) begin
            ctl.loadWord = 1'b1;
            ctl.clrRetry = 1'b1;
            stateD       = OP_CMD;
          end else begin
            trapD = 1'b1;
          end
        end
      end
      OP_CMD: begin
        if (busReady) stateD = OP_RESP;
      end
      OP_RESP: begin
        if (busReady) begin
          case (respE'(respCode))
            RC_DONE: begin
              doneD  = 1'b1;
              stateD = OP_NONE;
            end
            RC_BUSY: begin
              if (retryMax) begin
                trapD  = 1'b1;
                stateD = OP_NONE;
              end else begin
                ctl.bumpRetry = 1'b1;
              end
            end
            RC_FETCH: stateD = OP_FADDR;
            default: begin
              trapD  = 1'b1;
              stateD = OP_NONE;
            end
          endcase
        end
      end
      OP_FADDR: begin
        if (busReady) begin
          ctl.loadAddr = 1'b1;
          stateD       = OP_MEM;
        end
      end
      OP_MEM: begin
        if (busReady) begin
          ctl.loadData = 1'b1;
          stateD       = OP_OPND;
        end
      end
      OP_OPND: begin
        if (busReady) stateD = OP_RESP;
      end
      default: stateD = OP_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= OP_NONE;
      trap   <= 1'b0;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      trap   <= trapD;
      done   <= doneD;
    end
  end

endmodule

// File: rtl/cpDispatchPath.sv
module cpDispatchPath
  import cpDispatchPkg::*;
#(
  parameter int INSTR_W     = 16,
  parameter int ID_W        = 3,
  parameter int TYPE_W      = 3,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int ID_SHIFT    = 13,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h0A,
  parameter logic [ADDR_W-1:0] RESP_OFS = 'h00,
  parameter logic [ADDR_W-1:0] OPND_OFS = 'h10,
  parameter int RETRY_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INSTR_W-1:0] instrWord,
  input  ctlS               ctl,
  input  logic [DATA_W-1:0] busRData,
  output logic              isCp,
  output logic [ID_W-1:0]   inCpId,
  output logic [TYPE_W-1:0] inOpType,
  output logic [1:0]        respCode,
  output logic              retryMax,
  output logic              busValid,
  output logic              busWrite,
  output logic              busSpace,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWData
);

  localparam int PFX_W  = 4;
  localparam int ID_HI  = INSTR_W - PFX_W - 1;
  localparam int TY_HI  = ID_HI - ID_W;
  localparam int RTRY_W = $clog2(RETRY_LIMIT + 1);

  logic [INSTR_W-1:0] wordQ;
  logic [ADDR_W-1:0]  fetchAddrQ;
  logic [DATA_W-1:0]  operandQ;
  logic [RTRY_W-1:0]  retryQ;
  logic [ID_W-1:0]    heldId;
  logic [ADDR_W-1:0]  cpBase;

  // Live decode of the offered word.
  assign isCp     = (instrWord[INSTR_W-1 -: PFX_W] == {PFX_W{1'b1}});
  assign inCpId   = instrWord[ID_HI -: ID_W];
  assign inOpType = instrWord[TY_HI -: TYPE_W];

  assign respCode = busRData[1:0];
  assign retryMax = (retryQ == RTRY_W'(RETRY_LIMIT - 1));

  // Registers captured during a dispatch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ      <= '0;
      fetchAddrQ <= '0;
      operandQ   <= '0;
      retryQ     <= '0;
    end else begin
      if (ctl.loadWord) wordQ      <= instrWord;
      if (ctl.loadAddr) fetchAddrQ <= busRData[ADDR_W-1:0];
      if (ctl.loadData) operandQ   <= busRData;
      if (ctl.clrRetry)       retryQ <= '0;
      else if (ctl.bumpRetry) retryQ <= retryQ + 1'b1;
    end
  end

  assign heldId = wordQ[ID_HI -: ID_W];
  assign cpBase = ADDR_W'(heldId) << ID_SHIFT;

  // Bus fields follow the registered operation, so they hold until ready.
  always_comb begin
    busValid = (ctl.op != OP_NONE);
    busWrite = 1'b0;
    busSpace = 1'b1;
    busAddr  = '0;
    busWData = '0;
    case (ctl.op)
      OP_CMD: begin
        busWrite = 1'b1;
        busAddr  = cpBase | CMD_OFS;
        busWData = DATA_W'(wordQ);
      end
      OP_RESP, OP_FADDR: busAddr = cpBase | RESP_OFS;
      OP_MEM: begin
        busSpace = 1'b0;
        busAddr  = fetchAddrQ;
      end
      OP_OPND: begin
        busWrite = 1'b1;
        busAddr  = cpBase | OPND_OFS;
        busWData = operandQ;
      end
      default: busSpace = 1'b1;
    endcase
  end

endmodule

// File: rtl/cpDispatch.sv
module cpDispatch
  import cpDispatchPkg::*;
#(
  parameter int INSTR_W     = 16,
  parameter int ID_W        = 3,
  parameter int TYPE_W      = 3,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int ID_SHIFT    = 13,
  parameter logic [(1<<ID_W)-1:0] PRESENT_MASK = 'b11,
  parameter int RETRY_LIMIT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output logic               instrReady,
  output logic               passThru,
  output logic [ID_W-1:0]    decCpId,
  output logic [TYPE_W-1:0]  decOpType,
  output logic               trap,
  output logic               done,
  output logic               busValid,
  output logic               busWrite,
  output logic               busSpace,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busWData,
  input  logic               busReady,
  input  logic [DATA_W-1:0]  busRData
);

  ctlS        ctl;
  logic       isCp;
  logic [1:0] respCode;
  logic       retryMax;

  cpDispatchCtrl #(
    .ID_W(ID_W), .PRESENT_MASK(PRESENT_MASK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .isCp(isCp),
    .inCpId(decCpId), .busReady(busReady), .respCode(respCode),
    .retryMax(retryMax), .ctl(ctl), .instrReady(instrReady),
    .passThru(passThru), .trap(trap), .done(done)
  );

  cpDispatchPath #(
    .INSTR_W(INSTR_W), .ID_W(ID_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .ID_SHIFT(ID_SHIFT), .RETRY_LIMIT(RETRY_LIMIT)
  ) uPath (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .ctl(ctl),
    .busRData(busRData), .isCp(isCp), .inCpId(decCpId),
    .inOpType(decOpType), .respCode(respCode), .retryMax(retryMax),
    .busValid(busValid), .busWrite(busWrite), .busSpace(busSpace),
    .busAddr(busAddr), .busWData(busWData)
  );

endmodule

// File: rtl/cpDispatchChk.sv
module cpDispatchChk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrReady,
  input logic              passThru,
  input logic              trap,
  input logic              done,
  input logic              busValid,
  input logic              busWrite,
  input logic              busSpace,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWData,
  input logic              busReady
);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(busAddr) && $stable(busWData)
                              && $stable(busWrite) && $stable(busSpace));

  // R1
  pass_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    passThru |=> !busValid);

  // R7
  mem_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busSpace |-> !busWrite);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrReady |-> !busValid);

  // R5
  release_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> instrReady && !trap);

  // R10
  trap_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> instrReady && !busValid);

endmodule

bind cpDispatch cpDispatchChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .instrReady(instrReady), .passThru(passThru),
  .trap(trap), .done(done), .busValid(busValid), .busWrite(busWrite),
  .busSpace(busSpace), .busAddr(busAddr), .busWData(busWData),
  .busReady(busReady)
);

// File: tb/sim_cpDispatch.sv
module sim_cpDispatch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        instrReady, passThru, trap, done;
  logic [2:0]  decCpId, decOpType;
  logic        busValid, busWrite, busSpace;
  logic [31:0] busAddr, busWData;
  logic        busReady = 1'b0;
  logic [31:0] busRData = '0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cpDispatch u0 (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .instrReady(instrReady), .passThru(passThru), .decCpId(decCpId),
    .decOpType(decOpType), .trap(trap), .done(done), .busValid(busValid),
    .busWrite(busWrite), .busSpace(busSpace), .busAddr(busAddr),
    .busWData(busWData), .busReady(busReady), .busRData(busRData)
  );

  // outcome: 0 pass-through, 1 release, 2 trap
  typedef struct packed {
    logic [15:0] word;
    logic [4:0]  nBusy;
    logic        fetch;
    logic [31:0] fAddr;
    logic [31:0] mData;
    logic [1:0]  finalCode;
    logic [1:0]  outcome;
  } vecS;

  localparam vecS VECS [8] = '{
    '{16'h1234, 5'd0,  1'b0, 32'h0,         32'h0,         2'b00, 2'd0},
    '{16'hF240, 5'd0,  1'b0, 32'h0,         32'h0,         2'b00, 2'd1},
    '{16'hF0C5, 5'd3,  1'b1, 32'h0000_8000, 32'hDEAD_BEEF, 2'b00, 2'd1},
    '{16'hF600, 5'd0,  1'b0, 32'h0,         32'h0,         2'b00, 2'd2},
    '{16'hF27F, 5'd0,  1'b0, 32'h0,         32'h0,         2'b11, 2'd2},
    '{16'hF200, 5'd15, 1'b0, 32'h0,         32'h0,         2'b00, 2'd1},
    '{16'hF200, 5'd16, 1'b0, 32'h0,         32'h0,         2'b00, 2'd2},
    '{16'hE000, 5'd0,  1'b0, 32'h0,         32'h0,         2'b00, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Serve one bus transaction. Entered and left at a falling edge.
  task automatic serve(input string req, input bit expWr, input bit expSp,
                       input logic [31:0] expAddr, input logic [31:0] expData,
                       input logic [31:0] rdata, input int stall);
    int waitCnt = 0;
    while (!busValid && waitCnt < 4) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(busValid && !instrReady, req, "request", {30'b0, busValid, instrReady}, 32'h2);
    chk(busWrite == expWr && busSpace == expSp, req, "dir/space",
        {30'b0, busWrite, busSpace}, {30'b0, expWr, expSp});
    chk(busAddr == expAddr, req, "address", busAddr, expAddr);
    if (expWr) chk(busWData == expData, req, "write data", busWData, expData);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      // R8 held while stalled
      chk(busValid && busAddr == expAddr, "R8", "held address", busAddr, expAddr);
    end
    busReady = 1'b1;
    busRData = rdata;
    @(negedge clk);
    busReady = 1'b0;
    busRData = '0;
  endtask

  task automatic runVec(input vecS v, input int idx);
    logic [2:0]  id   = v.word[11:9];
    logic [31:0] base = {16'b0, 3'b0, id, 10'b0} << 3;
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = v.word;
    #1;
    // R1
    chk(passThru == (v.word[15:12] != 4'hF), "R1", "passThru", {31'b0, passThru},
        {31'b0, v.word[15:12] != 4'hF});
    // R2
    chk(decCpId == v.word[11:9] && decOpType == v.word[8:6], "R2", "fields",
        {26'b0, decCpId, decOpType}, {26'b0, v.word[11:6]});
    @(negedge clk);
    instrValid = 1'b0;
    if (v.outcome == 2'd0) begin
      // R1 no bus activity
      chk(!busValid && instrReady, "R1", "quiet after pass", {31'b0, busValid}, 32'h0);
      return;
    end
    if (id > 3'd1) begin
      // R9
      chk(trap && !busValid, "R9", "absent id trap", {30'b0, trap, busValid}, 32'h2);
      @(negedge clk);
      chk(!trap && !busValid, "R9", "trap one cycle", {30'b0, trap, busValid}, 32'h0);
      return;
    end
    // R3
    serve("R3", 1'b1, 1'b1, base | 32'h0A, {16'b0, v.word}, 32'h0, idx % 3);
    if (v.fetch) begin
      // R7
      serve("R7", 1'b0, 1'b1, base, 32'h0, 32'h2, (idx + 1) % 3);
      serve("R7", 1'b0, 1'b1, base, 32'h0, v.fAddr, idx % 3);
      serve("R7", 1'b0, 1'b0, v.fAddr, 32'h0, v.mData, 1);
      serve("R7", 1'b1, 1'b1, base | 32'h10, v.mData, 32'h0, 2);
    end
    for (int b = 0; b < int'(v.nBusy); b++) begin
      // R6
      serve("R6", 1'b0, 1'b1, base, 32'h0, 32'h1, b % 2);
      if (b == 15) break;
    end
    if (v.nBusy < 5'd16) serve("R4", 1'b0, 1'b1, base, 32'h0, {30'b0, v.finalCode}, 1);
    // R5 / R10 / R6 outcome
    chk(done == (v.outcome == 2'd1), "R5", "done pulse", {31'b0, done},
        {31'b0, v.outcome == 2'd1});
    chk(trap == (v.outcome == 2'd2), "R10", "trap pulse", {31'b0, trap},
        {31'b0, v.outcome == 2'd2});
    @(negedge clk);
    chk(!busValid && !trap && !done && instrReady, "R10", "idle after end",
        {28'b0, busValid, trap, done, instrReady}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 during reset
    chk(instrReady && !busValid && !trap && !done, "R11", "reset state",
        {28'b0, instrReady, busValid, trap, done}, 32'h8);
    rstN = 1'b1;
    @(negedge clk);
    chk(instrReady && !busValid, "R11", "after reset", {30'b0, instrReady, busValid}, 32'h2);

    for (int i = 0; i < 8; i++) runVec(VECS[i], i);

    // R11 reset in the middle of a command write
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = 16'hF000;
    @(negedge clk);
    instrValid = 1'b0;
    chk(busValid && busWrite, "R11", "command started", {30'b0, busValid, busWrite}, 32'h3);
    rstN = 1'b0;
    #1;
    chk(!busValid && instrReady, "R11", "reset drops request",
        {30'b0, busValid, instrReady}, 32'h1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busValid && !trap && !done, "R11", "quiet after reset",
        {29'b0, busValid, trap, done}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule